// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Chain

This block holds the digital counters of an integer-N frequency synthesizer. Everything runs on one fast system clock. A strobe marks each crystal cycle and a second strobe marks each cycle of the VCO feedback signal. On the reference side the crystal strobes pass through a small selectable prescaler and then a fixed divide-by-128. This gives the comparison rate. On the feedback side the VCO strobes pass through a fixed divide-by-16, which is the halving stage and the divide-by-8 prescaler together. They then pass through a 12-bit programmable ratio N, where each step of N is a 250 kHz step of output frequency.

The two divided ticks feed a phase-frequency detector built from two set/clear flags. When both flags are high they stay high together for exactly one clock cycle and then clear, so the detector has no dead zone. A band divider taps a free-running counter of VCO strobes and produces a square wave at 1/2, 1/4, 1/8 or 1/16 of the strobe rate for low-band use.

A write of N is staged and reaches the counter only when the current feedback cycle ends. A write of zero is refused and raises an error flag. While standby is high, writes are dropped, the counters are parked and the outputs are held low.

Top module: `pll_divider_chain`

## Requirements
- R1: After reset, up, dn, band_clk and n_err are low, and the active ratio is N_RESET (2365), so fb_tick repeats every 37840 fb_en strobes.
- R2: ref_tick pulses once every 128*P ref_en strobes. P is 1 for xp_sel=0, 2 for xp_sel=1, and 4 for xp_sel=2 or 3. ref_tick is never high in a cycle where ref_en is low.
- R3: fb_tick pulses once every 16*N fb_en strobes and is never high in a cycle where fb_en is low.
- R4: A write with n_data=0 leaves the active ratio unchanged, and n_err reads high from the next cycle on.
- R5: An accepted write of a nonzero value clears n_err from the next cycle on.
- R6: While stby is high, n_wr has no effect: both the ratio and n_err keep their values.
- R7: A new N applies only after the feedback cycle in progress has completed with the old N. The interval that contains the write keeps the old length.
- R8: band_sel values 0..3 give a band_clk square wave whose period is 2, 4, 8 or 16 fb_en strobes. band_sel values 4..7 hold band_clk low.
- R9: A ref_tick raises up on the next cycle and a fb_tick raises dn on the next cycle. Each stays high until the other flag also rises.
- R10: Once up and dn are both high, they stay high together for exactly one cycle and are then both low.
- R11: From the cycle after stby is sampled high, up, dn and band_clk are low. All counters restart from zero when stby drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Standby: parks counters, blocks ratio writes |
| ref_en | input | 1 | Strobe, one per crystal cycle |
| fb_en | input | 1 | Strobe, one per VCO cycle |
| xp_sel | input | 2 | Crystal prescaler select (/1, /2, /4, /4) |
| n_wr | input | 1 | Write strobe for the feedback ratio |
| n_data | input | 12 | Feedback ratio value |
| band_sel | input | 3 | Band divider select |
| up | output | 1 | Detector pump-up flag |
| dn | output | 1 | Detector pump-down flag |
| ref_tick | output | 1 | One-cycle pulse at each reference division |
| fb_tick | output | 1 | One-cycle pulse at each feedback division |
| band_clk | output | 1 | Divided band output |
| n_err | output | 1 | Set by a refused zero-ratio write |

## Verification
The bench writes a new ratio in the middle of a feedback interval and checks the lengths of that interval and the next one. A design that loads at once would give a runt interval, and one that loads late would stretch a second interval. Zero writes and writes during standby are checked by measuring the feedback period afterwards and by reading n_err. A design that accepts either would show a changed period or a raised flag. The detector is driven with a reference tick alone and then with a feedback tick, which exposes a missing overlap cycle (dead zone) or a flag that never clears. The prescaler and band selects are swept, including the duplicate prescaler code and a disabled band code.

// File: rtl/pll_divider_chain.sv
module pll_divider_chain #(
  parameter int NW          = 12,
  parameter int REF_DIV     = 128,
  parameter int FB_PRE      = 16,
  parameter int N_RESET     = 2365,
  parameter int BAND_STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby,
  input  logic          ref_en,
  input  logic          fb_en,
  input  logic [1:0]    xp_sel,
  input  logic          n_wr,
  input  logic [NW-1:0] n_data,
  input  logic [2:0]    band_sel,
  output logic          up,
  output logic          dn,
  output logic          ref_tick,
  output logic          fb_tick,
  output logic          band_clk,
  output logic          n_err
);
  localparam int RW = $clog2(REF_DIV);
  localparam int PW = $clog2(FB_PRE);
  localparam int BW = BAND_STAGES;

  logic [1:0]    xp_cnt, xp_lim;
  logic [RW-1:0] r_cnt;
  logic [PW-1:0] p_cnt;
  logic [NW-1:0] n_cnt, n_cur, n_pend;
  logic [BW-1:0] b_cnt;
  logic          xp_tick, pre_tick, n_last;

  always_comb
    case (xp_sel)
      2'd0:    xp_lim = 2'd0;
      2'd1:    xp_lim = 2'd1;
      default: xp_lim = 2'd3;
    endcase

  assign xp_tick  = !stby && ref_en && (xp_cnt >= xp_lim);
  assign ref_tick = xp_tick && (r_cnt == RW'(REF_DIV - 1));
  assign pre_tick = !stby && fb_en && (p_cnt == PW'(FB_PRE - 1));
  assign n_last   = (n_cnt == n_cur - 1'b1);
  assign fb_tick  = pre_tick && n_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xp_cnt <= '0;
      r_cnt  <= '0;
    end else if (stby) begin
      xp_cnt <= '0;
      r_cnt  <= '0;
    end else if (ref_en) begin
      xp_cnt <= (xp_cnt >= xp_lim) ? 2'd0 : xp_cnt + 2'd1;
      if (xp_tick)
        r_cnt <= (r_cnt == RW'(REF_DIV - 1)) ? '0 : r_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_cnt <= '0;
      n_cnt <= '0;
      n_cur <= NW'(N_RESET);
      b_cnt <= '0;
    end else if (stby) begin
      p_cnt <= '0;
      n_cnt <= '0;
      b_cnt <= '0;
    end else if (fb_en) begin
      p_cnt <= (p_cnt == PW'(FB_PRE - 1)) ? '0 : p_cnt + 1'b1;
      b_cnt <= b_cnt + 1'b1;
      if (pre_tick) begin
        if (n_last) begin
          n_cnt <= '0;
          n_cur <= n_pend;
        end else begin
          n_cnt <= n_cnt + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_pend <= NW'(N_RESET);
      n_err  <= 1'b0;
    end else if (n_wr && !stby) begin
      if (n_data == '0) begin
        n_err <= 1'b1;
      end else begin
        n_pend <= n_data;
        n_err  <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (stby) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      up <= ref_tick;
      dn <= fb_tick;
    end else begin
      up <= up | ref_tick;
      dn <= dn | fb_tick;
    end

  always_comb begin
    band_clk = 1'b0;
    for (int i = 0; i < BW; i++)
      if (int'(band_sel) == i) band_clk = b_cnt[i];
  end
endmodule

// File: rtl/pll_divider_chain_chk.sv
module pll_divider_chain_chk #(
  parameter int NW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby,
  input logic          ref_en,
  input logic          fb_en,
  input logic          n_wr,
  input logic [NW-1:0] n_data,
  input logic [2:0]    band_sel,
  input logic          up,
  input logic          dn,
  input logic          ref_tick,
  input logic          fb_tick,
  input logic          band_clk,
  input logic          n_err
);
  // R2
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |-> !ref_tick);
  // R3
  fb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_en |-> !fb_tick);
  // R4
  zero_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_wr && !stby && n_data == '0) |=> n_err);
  // R5
  good_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_wr && !stby && n_data != '0) |=> !n_err);
  // R6
  stby_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> $stable(n_err));
  // R8
  band_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_sel >= 3'd4) |-> !band_clk);
  // R9
  up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !(up && dn)) |=> up);
  // R9
  dn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_tick && !(up && dn)) |=> dn);
  // R10
  overlap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn && !ref_tick && !fb_tick) |=> (!up && !dn));
  // R11
  stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (!up && !dn && !band_clk));
endmodule

bind pll_divider_chain pll_divider_chain_chk #(.NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stby(stby), .ref_en(ref_en), .fb_en(fb_en),
  .n_wr(n_wr), .n_data(n_data), .band_sel(band_sel), .up(up), .dn(dn),
  .ref_tick(ref_tick), .fb_tick(fb_tick), .band_clk(band_clk), .n_err(n_err)
);

// File: tb/pll_divider_chain_test.sv
`timescale 1ns/1ps
module pll_divider_chain_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0;
  logic        ref_en = 1'b0;
  logic        fb_en = 1'b0;
  logic [1:0]  xp_sel = 2'd0;
  logic        n_wr = 1'b0;
  logic [11:0] n_data = '0;
  logic [2:0]  band_sel = 3'd0;
  logic        up, dn, ref_tick, fb_tick, band_clk, n_err;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  // columns: xp_sel, N, expected ref period, expected fb period
  localparam int TBL [5][4] = '{
    '{0,  1, 128,  16},
    '{1,  3, 256,  48},
    '{2, 40, 512, 640},
    '{3,  5, 512,  80},
    '{2, 10, 512, 160}
  };

  pll_divider_chain uut (
    .clk(clk), .rst_n(rst_n), .stby(stby), .ref_en(ref_en), .fb_en(fb_en),
    .xp_sel(xp_sel), .n_wr(n_wr), .n_data(n_data), .band_sel(band_sel),
    .up(up), .dn(dn), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .band_clk(band_clk), .n_err(n_err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fb(output int t);
    while (!fb_tick) @(negedge clk);
    t = cyc;
    @(negedge clk);
  endtask

  task automatic meas_fb(output int p);
    int t0, t1;
    wait_fb(t0);
    wait_fb(t1);
    p = t1 - t0;
  endtask

  task automatic meas_ref(output int p);
    int t0;
    while (!ref_tick) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!ref_tick) @(negedge clk);
    p = cyc - t0;
    @(negedge clk);
  endtask

  task automatic meas_band(output int p);
    int t0;
    while (band_clk) @(negedge clk);
    while (!band_clk) @(negedge clk);
    t0 = cyc;
    while (band_clk) @(negedge clk);
    while (!band_clk) @(negedge clk);
    p = cyc - t0;
  endtask

  task automatic write_n(input int v);
    n_data = 12'(v);
    n_wr = 1'b1;
    @(negedge clk);
    n_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (R3): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p, t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!up && !dn && !band_clk && !n_err, "R1 reset outputs", {up, dn, band_clk, n_err}, 0);
    ref_en = 1'b1;
    fb_en = 1'b1;
    meas_fb(p);
    check(p == 37840, "R1 default ratio period", p, 37840);

    // R2 / R3 vector table
    for (int k = 0; k < 5; k++) begin
      xp_sel = 2'(TBL[k][0]);
      write_n(TBL[k][1]);
      meas_ref(p);
      check(p == TBL[k][2], "R2 reference period", p, TBL[k][2]);
      meas_fb(p);
      check(p == TBL[k][3], "R3 feedback period", p, TBL[k][3]);
    end

    // R7 mid-interval update keeps the current interval
    wait_fb(t0);
    repeat (40) @(negedge clk);
    write_n(2);
    wait_fb(t1);
    check(t1 - t0 == 160, "R7 interval holding the write", t1 - t0, 160);
    wait_fb(t2);
    check(t2 - t1 == 32, "R7 first interval with new N", t2 - t1, 32);

    // R4 zero write refused
    write_n(0);
    check(n_err == 1'b1, "R4 error flag", n_err, 1);
    meas_fb(p);
    check(p == 32, "R4 ratio kept", p, 32);

    // R5 valid write clears flag
    write_n(3);
    check(n_err == 1'b0, "R5 error flag cleared", n_err, 0);
    meas_fb(p);
    check(p == 48, "R5 new ratio", p, 48);

    // R11 / R6 standby
    stby = 1'b1;
    @(negedge clk);
    check(!up && !dn && !band_clk, "R11 outputs low in standby", {up, dn, band_clk}, 0);
    write_n(7);
    write_n(0);
    check(n_err == 1'b0, "R6 flag unchanged in standby", n_err, 0);
    stby = 1'b0;
    meas_fb(p);
    check(p == 48, "R6 ratio unchanged after standby", p, 48);

    // R8 band divider
    for (int s = 0; s < 4; s++) begin
      band_sel = 3'(s);
      meas_band(p);
      check(p == (2 << s), "R8 band period", p, 2 << s);
    end
    band_sel = 3'd5;
    @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        if (band_clk) hi++;
        @(negedge clk);
      end
      check(hi == 0, "R8 band disabled code", hi, 0);
    end

    // R9 / R10 detector
    stby = 1'b1;
    ref_en = 1'b0;
    fb_en = 1'b0;
    @(negedge clk);
    stby = 1'b0;
    @(negedge clk);
    check(!up && !dn, "R11 detector clear after standby", {up, dn}, 0);
    xp_sel = 2'd0;
    ref_en = 1'b1;
    while (!ref_tick) @(negedge clk);
    @(posedge clk);
    #1 ref_en = 1'b0;
    @(negedge clk);
    check(up && !dn, "R9 up after reference tick", {up, dn}, 2);
    repeat (10) @(negedge clk);
    check(up && !dn, "R9 up held", {up, dn}, 2);
    fb_en = 1'b1;
    while (!fb_tick) @(negedge clk);
    @(posedge clk);
    #1 fb_en = 1'b0;
    @(negedge clk);
    check(up && dn, "R10 overlap cycle", {up, dn}, 3);
    @(negedge clk);
    check(!up && !dn, "R10 both cleared", {up, dn}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule